// File: doc/BRIEF.md
# Commutation Mode Switchover Controller

This block chooses between two ways of driving a three-phase brushless motor. In plain mode, each 120-degree commutation step switches the PWM duty at once. In slope mode, the duty is ramped gradually across each step so that phase changes make less audible noise. The block always starts in plain mode. It allows slope mode only when the rotor is clearly turning: the hall U signal must repeat faster than a minimum rate, and it must do so for a run of consecutive periods. Whenever the speed falls, the drive is put in standby, or slope operation is disabled, the block returns to plain mode.

The three hall inputs are synchronised and edge-detected inside the block. The time between rising edges of hall U is measured in clock cycles and compared against a limit set by a parameter. The default limit is a third of a second at 100 MHz, which corresponds to a minimum of about 3 Hz. A downstream PWM stage reads the mode flag and a ramp index. The index restarts at every commutation edge and climbs in equal time slices, each slice one step of the ramp, until the next edge.

Top module: `commute_mode_ctrl`

## Requirements
- R1: After reset, slopeMode is 0 and rampIdx is 0.
- R2: While slopeEnable is 0, slopeMode is 0 from the next clock on. The count of qualifying edges is kept meanwhile, so that after slopeEnable returns to 1, a single further qualifying rise selects slope mode.
- R3: slopeMode goes to 1 on the EDGE_TARGET-th consecutive qualifying rising edge of hall U (default 7). After reset this is the eighth rise, and slope mode is not selected earlier.
- R4: A rise of hall U qualifies when it comes at most PERIOD_LIMIT clock cycles after the previous rise. The first rise after reset, after standby or after a timeout only starts the measurement and is not counted. A gap of PERIOD_LIMIT+1 cycles does not qualify.
- R5: If PERIOD_LIMIT cycles pass with no rise of hall U, the block returns to plain mode and clears the count. A fresh run of EDGE_TARGET qualifying rises is then needed.
- R6: While runActive is 0 (standby), slopeMode is 0 from the next clock on, the count is cleared and period measurement restarts. Leaving standby needs a full fresh run of qualifying rises.
- R7: In slope mode, a change on any hall input sets rampIdx to 0. After that, rampIdx advances by one every S cycles, where S = (last commutation interval in cycles) >> RAMP_SHIFT, with a minimum of 1. rampIdx stops at 2^RAMP_SHIFT-1. With equally spaced hall steps of H cycles, rampIdx is floor(j/S) j cycles after the step.
- R8: In plain mode, rampIdx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hallU | input | 1 | Hall sensor U, asynchronous; its period sets the speed estimate |
| hallV | input | 1 | Hall sensor V, asynchronous |
| hallW | input | 1 | Hall sensor W, asynchronous |
| slopeEnable | input | 1 | 1 allows slope mode; 0 forces plain mode |
| runActive | input | 1 | 1 run, 0 standby |
| slopeMode | output | 1 | 1 slope commutation, 0 plain commutation |
| rampIdx | output | RAMP_SHIFT | Ramp step within the current commutation interval |

## Verification
A wrong edge count or a wrong period measurement shows up only at the edge where the mode should change. Slope mode then appears one qualifying rise too early or too late, or it survives a gap that should have cleared it. For this reason the bench lays out exact rise sequences and checks slopeMode a few cycles after each decisive rise: the seventh and eighth rise, and gaps of exactly the limit and one cycle more. A wrong step-length or ramp counter appears within a single commutation interval as an index that is held too long or too short. The bench therefore compares every cycle of a full interval against floor(j/S), at two different hall speeds.

// File: rtl/commute_pkg.sv
package commute_pkg;

  typedef enum logic {
    MODE_PLAIN = 1'b0,
    MODE_SLOPE = 1'b1
  } drive_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic periodRestart;
    logic periodPark;
    logic edgeInc;
    logic edgeClr;
    logic rampRun;
  } dp_strobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic uRise;
    logic periodParked;
    logic periodExpiring;
    logic edgeReady;
  } dp_status_t;

endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] rawIn,
  output logic         firstRise,
  output logic         anyChange
);
  logic [W-1:0] stage1, stage2, lastSeen;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1[b]   <= 1'b0;
        stage2[b]   <= 1'b0;
        lastSeen[b] <= 1'b0;
      end else begin
        stage1[b]   <= rawIn[b];
        stage2[b]   <= stage1[b];
        lastSeen[b] <= stage2[b];
      end
    end
  end

  assign firstRise = stage2[0] & ~lastSeen[0];
  assign anyChange = |(stage2 ^ lastSeen);
endmodule

// File: rtl/commute_datapath.sv
module commute_datapath
  import commute_pkg::*;
#(
  parameter int PERIOD_LIMIT = 33_333_333,
  parameter int EDGE_TARGET  = 7,
  parameter int RAMP_SHIFT   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  uRise,
  input  logic                  anyEdge,
  input  dp_strobe_t            stb,
  output dp_status_t            status,
  output logic [RAMP_SHIFT-1:0] rampIdx
);
  localparam int PER_W  = $clog2(PERIOD_LIMIT + 1);
  localparam int EDGE_W = $clog2(EDGE_TARGET + 1);
  localparam logic [PER_W-1:0]      LIMIT_V  = PER_W'(PERIOD_LIMIT);
  localparam logic [EDGE_W-1:0]     TARGET_V = EDGE_W'(EDGE_TARGET);
  localparam logic [RAMP_SHIFT-1:0] RAMP_TOP = '1;

  logic [PER_W-1:0]  periodCnt, commCnt, lastInterval, stepCnt, stepLen;
  logic [EDGE_W-1:0] edgeCnt;

  // Hall U period counter, parked at the limit when no valid reference
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     periodCnt <= LIMIT_V;
    else if (stb.periodPark)       periodCnt <= LIMIT_V;
    else if (stb.periodRestart)    periodCnt <= '0;
    else if (periodCnt != LIMIT_V) periodCnt <= periodCnt + PER_W'(1);
  end

  // Consecutive qualifying rise counter, saturating at the target
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     edgeCnt <= '0;
    else if (stb.edgeClr)                          edgeCnt <= '0;
    else if (stb.edgeInc && edgeCnt != TARGET_V)   edgeCnt <= edgeCnt + EDGE_W'(1);
  end

  // Commutation interval measurement (any hall change)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commCnt      <= '0;
      lastInterval <= '0;
    end else if (anyEdge) begin
      commCnt      <= '0;
      lastInterval <= (commCnt == LIMIT_V) ? LIMIT_V : commCnt + PER_W'(1);
    end else if (commCnt != LIMIT_V) begin
      commCnt <= commCnt + PER_W'(1);
    end
  end

  always_comb begin
    stepLen = lastInterval >> RAMP_SHIFT;
    if (stepLen == '0) stepLen = PER_W'(1);
  end

  // Ramp index: restarts at each commutation, advances every stepLen cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
      rampIdx <= '0;
    end else if (!stb.rampRun || anyEdge) begin
      stepCnt <= '0;
      rampIdx <= '0;
    end else if (stepCnt >= stepLen - PER_W'(1)) begin
      stepCnt <= '0;
      if (rampIdx != RAMP_TOP) rampIdx <= rampIdx + RAMP_SHIFT'(1);
    end else begin
      stepCnt <= stepCnt + PER_W'(1);
    end
  end

  assign status.uRise          = uRise;
  assign status.periodParked   = (periodCnt == LIMIT_V);
  assign status.periodExpiring = (periodCnt == LIMIT_V - PER_W'(1));
  assign status.edgeReady      = (edgeCnt >= TARGET_V - EDGE_W'(1));

  assert_edge_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= TARGET_V);

  assert_unreferenced_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    (uRise && periodCnt == LIMIT_V) |=> (edgeCnt == '0));

  assert_timeout_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!uRise && periodCnt == LIMIT_V - PER_W'(1)) |=> (edgeCnt == '0));

  assert_ramp_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rampIdx != $past(rampIdx)) |->
      (rampIdx == '0 || rampIdx == $past(rampIdx) + RAMP_SHIFT'(1)));

  assert_ramp_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rampRun |=> (rampIdx == '0));
endmodule

// File: rtl/commute_ctrl.sv
module commute_ctrl
  import commute_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       slopeEnable,
  input  logic       runActive,
  input  dp_status_t status,
  output dp_strobe_t stb,
  output logic       slopeMode
);
  drive_mode_e modeQ, modeD;
  logic qualRise, timeout;

  assign qualRise = runActive && status.uRise && !status.periodParked;
  assign timeout  = runActive && !status.uRise && status.periodExpiring;

  always_comb begin
    stb.periodPark    = !runActive;
    stb.periodRestart = status.uRise;
    stb.edgeInc       = qualRise;
    stb.edgeClr       = !runActive || timeout || (status.uRise && status.periodParked);
    stb.rampRun       = (modeQ == MODE_SLOPE);
  end

  always_comb begin
    modeD = modeQ;
    case (modeQ)
      MODE_PLAIN: if (slopeEnable && qualRise && status.edgeReady) modeD = MODE_SLOPE;
      MODE_SLOPE: if (!slopeEnable || !runActive || timeout)        modeD = MODE_PLAIN;
      default:    modeD = MODE_PLAIN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_PLAIN;
    else       modeQ <= modeD;
  end

  assign slopeMode = (modeQ == MODE_SLOPE);

  assert_disable_forces_plain_R2: assert property (@(posedge clk) disable iff (!rstN)
    !slopeEnable |=> !slopeMode);

  assert_entry_on_ready_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slopeMode) |-> $past(status.uRise && status.edgeReady && !status.periodParked));

  assert_standby_plain_R6: assert property (@(posedge clk) disable iff (!rstN)
    !runActive |=> !slopeMode);
endmodule

// File: rtl/commute_mode_ctrl.sv
module commute_mode_ctrl
  import commute_pkg::*;
#(
  parameter int PERIOD_LIMIT = 33_333_333,
  parameter int EDGE_TARGET  = 7,
  parameter int RAMP_SHIFT   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hallU,
  input  logic                  hallV,
  input  logic                  hallW,
  input  logic                  slopeEnable,
  input  logic                  runActive,
  output logic                  slopeMode,
  output logic [RAMP_SHIFT-1:0] rampIdx
);
  logic       uRise, anyEdge;
  dp_strobe_t stb;
  dp_status_t status;

  hall_sync #(.W(3)) u_sync (
    .clk       (clk),
    .rstN      (rstN),
    .rawIn     ({hallW, hallV, hallU}),
    .firstRise (uRise),
    .anyChange (anyEdge)
  );

  commute_datapath #(
    .PERIOD_LIMIT (PERIOD_LIMIT),
    .EDGE_TARGET  (EDGE_TARGET),
    .RAMP_SHIFT   (RAMP_SHIFT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .uRise   (uRise),
    .anyEdge (anyEdge),
    .stb     (stb),
    .status  (status),
    .rampIdx (rampIdx)
  );

  commute_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .slopeEnable (slopeEnable),
    .runActive   (runActive),
    .status      (status),
    .stb         (stb),
    .slopeMode   (slopeMode)
  );
endmodule

// File: tb/commute_mode_ctrl_bench.sv
module commute_mode_ctrl_bench;
  localparam int LIMIT  = 1000;
  localparam int TARGET = 7;
  localparam int SHIFT  = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic hallU = 1'b0, hallV = 1'b0, hallW = 1'b0;
  logic slopeEnable = 1'b1, runActive = 1'b1;
  logic slopeMode;
  logic [SHIFT-1:0] rampIdx;

  int checks = 0, fails = 0, phase = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  commute_mode_ctrl #(.PERIOD_LIMIT(LIMIT), .EDGE_TARGET(TARGET), .RAMP_SHIFT(SHIFT)) u_commute_mode_ctrl (
    .clk(clk), .rstN(rstN), .hallU(hallU), .hallV(hallV), .hallW(hallW),
    .slopeEnable(slopeEnable), .runActive(runActive),
    .slopeMode(slopeMode), .rampIdx(rampIdx)
  );

  task automatic check(bit ok, string tag, int actual, int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectMode(int exp, string tag);
    check(int'(slopeMode) == exp, tag, int'(slopeMode), exp);
  endtask

  // n rises of hall U spaced 'period' cycles; returns 6 cycles after the last half-high
  task automatic uRises(int n, int period);
    for (int i = 0; i < n; i++) begin
      hallU = 1'b1;
      cyc(period / 2);
      hallU = 1'b0;
      if (i < n - 1) cyc(period - period / 2);
      else cyc(6);
    end
  endtask

  task automatic standbyPulse();
    runActive = 1'b0;
    cyc(3);
    runActive = 1'b1;
    cyc(2);
  endtask

  function automatic logic [2:0] pattern(int p);
    case (p)
      0: return 3'b101;
      1: return 3'b100;
      2: return 3'b110;
      3: return 3'b010;
      4: return 3'b011;
      default: return 3'b001;
    endcase
  endfunction

  task automatic sixStep(int n, int h);
    for (int i = 0; i < n; i++) begin
      {hallU, hallV, hallW} = pattern(phase);
      phase = (phase + 1) % 6;
      cyc(h);
    end
  endtask

  // R7: compare one whole commutation interval against floor(j/S)
  task automatic rampWindow(int h, int s, string tag);
    int bad = 0, firstBad = -1, firstAct = 0;
    for (int k = 0; k < 20000 && !slopeMode; k++) cyc(1);
    for (int k = 0; k < 2000 && int'(rampIdx) != (1 << SHIFT) - 1; k++) cyc(1);
    for (int k = 0; k < 2000 && rampIdx != '0; k++) cyc(1);
    for (int j = 0; j < h; j++) begin
      int exp = j / s;
      if (exp > (1 << SHIFT) - 1) exp = (1 << SHIFT) - 1;
      if (int'(rampIdx) != exp) begin
        bad++;
        if (firstBad < 0) begin firstBad = exp; firstAct = int'(rampIdx); end
      end
      cyc(1);
    end
    check(bad == 0, tag, firstAct, firstBad);
  endtask

  task automatic t_reset();
    expectMode(0, "R1 mode after reset");
    check(rampIdx == '0, "R1 ramp after reset", int'(rampIdx), 0);
  endtask

  task automatic t_entry();
    uRises(7, 400);
    expectMode(0, "R3 seven rises not enough");
    uRises(1, 400);
    expectMode(1, "R3 eighth rise enters slope");
  endtask

  task automatic t_timeout();
    cyc(LIMIT + 10);
    expectMode(0, "R5 timeout returns to plain");
    uRises(7, 400);
    expectMode(0, "R5 count cleared by timeout");
    uRises(1, 400);
    expectMode(1, "R5 fresh run re-enters slope");
  endtask

  task automatic t_boundary();
    standbyPulse();
    uRises(8, LIMIT);
    expectMode(1, "R4 period equal to limit qualifies");
    standbyPulse();
    uRises(8, LIMIT + 1);
    expectMode(0, "R4 period one over limit rejected");
  endtask

  task automatic t_enable();
    standbyPulse();
    slopeEnable = 1'b0;
    uRises(8, 400);
    expectMode(0, "R2 disabled stays plain");
    check(rampIdx == '0, "R8 ramp zero in plain", int'(rampIdx), 0);
    slopeEnable = 1'b1;
    cyc(2);
    expectMode(0, "R2 enable alone does not switch");
    uRises(1, 400);
    expectMode(1, "R2 one rise after enable");
    slopeEnable = 1'b0;
    cyc(2);
    expectMode(0, "R2 disable drops slope");
    slopeEnable = 1'b1;
  endtask

  task automatic t_standby();
    uRises(1, 400);
    expectMode(1, "R6 back in slope before standby");
    runActive = 1'b0;
    cyc(2);
    expectMode(0, "R6 standby forces plain");
    runActive = 1'b1;
    cyc(2);
    uRises(7, 400);
    expectMode(0, "R6 count cleared by standby");
    uRises(1, 400);
    expectMode(1, "R6 full run after standby");
  endtask

  task automatic t_ramp();
    standbyPulse();
    check(rampIdx == '0, "R8 ramp zero after standby", int'(rampIdx), 0);
    fork
      sixStep(70, 64);
      rampWindow(64, 64 >> SHIFT, "R7 ramp at 64-cycle steps");
    join
    fork
      sixStep(30, 32);
      begin cyc(3 * 32); rampWindow(32, 32 >> SHIFT, "R7 ramp at 32-cycle steps"); end
    join
  endtask

  initial begin
    cyc(4);
    rstN = 1'b1;
    cyc(3);
    t_reset();
    t_entry();
    t_timeout();
    t_boundary();
    t_enable();
    t_standby();
    t_ramp();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1-all actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule